// File: doc/BRIEF.md
# Sticky Fault Flags with Maskable Interrupt

This block gathers fault conditions from a multi-lane optical link and holds each one in a flag bit until the host reads it. The conditions are per-lane loss-of-signal and transmitter-fault levels, plus the results of comparing monitor readings against high and low alarm limits. The monitor readings are one temperature (signed), one supply voltage (unsigned) and one received power per lane (unsigned). The limits arrive as inputs. The flags are grouped into read groups. Reading a group through the management slave clears that group.

Each flag has its own mask bit. The mask only keeps the flag from reaching the interrupt; the flag itself still latches. The interrupt is active low and meant for an open-drain pad. The same interrupt line announces that the module has finished initialising: after reset, a not-ready status bit stays high for a fixed number of cycles, then drops. When it drops, a completion flag is raised, and that flag pulls the line low without any host action.

Top module: `flag_int_ctrl`

## Requirements
- R1: A condition seen while the block is ready sets its flag at the next clock edge. The flag stays set after the condition goes away, until its group is read.
- R2: A read strobe (`rd_stb_i`=1) clears, at the next edge, the flags of the group named by `rd_grp_i`. The group codes are: 0 lane loss-of-signal, 1 lane transmitter fault, 2 status, 3 module monitors, 4 lane power. Flags of other groups are unchanged.
- R3: A condition that is present in the same cycle as the read of its group leaves the flag set after the read.
- R4: A set mask bit keeps its flag from driving the interrupt, but the flag still latches and can still be read.
- R5: `int_n_o` is 0 (line pulled low) while any unmasked flag or the completion flag is set. Otherwise it is 1 (released, high impedance at the pad).
- R6: Voltage and lane power are compared unsigned. The high flag is set when the value is greater than the high limit, and the low flag when it is less than the low limit. A value equal to a limit sets nothing. Module monitor bits: 0 temp high, 1 temp low, 2 volt high, 3 volt low. Lane c power bits: 2c high, 2c+1 low.
- R7: Temperature and its limits are compared as signed two's-complement 16-bit values, with the same strict greater/less rule as R6.
- R8: After reset, status bit 0 (not ready) is 1 for `INIT_CYCLES` clock edges and then drops to 0. In the same edge, status bit 1 (completion) goes to 1 and the interrupt is asserted. Reading the status group clears bit 1.
- R9: After reset, all flags are 0. No condition latches into a flag while the not-ready bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | NCH | Per-lane loss-of-signal level |
| txf_i | input | NCH | Per-lane transmitter fault level |
| temp_val_i | input | MW | Temperature reading, signed |
| temp_hi_lim_i | input | MW | Temperature high alarm limit, signed |
| temp_lo_lim_i | input | MW | Temperature low alarm limit, signed |
| volt_val_i | input | MW | Supply voltage reading, unsigned |
| volt_hi_lim_i | input | MW | Voltage high alarm limit |
| volt_lo_lim_i | input | MW | Voltage low alarm limit |
| pwr_val_i | input | NCH*MW | Lane power readings, lane c at bits c*MW upward |
| pwr_hi_lim_i | input | MW | Power high alarm limit, shared by lanes |
| pwr_lo_lim_i | input | MW | Power low alarm limit, shared by lanes |
| los_mask_i | input | NCH | Loss-of-signal interrupt masks |
| txf_mask_i | input | NCH | Transmitter fault interrupt masks |
| mod_mask_i | input | 4 | Module monitor interrupt masks |
| pwr_mask_i | input | 2*NCH | Lane power interrupt masks |
| rd_stb_i | input | 1 | Group read strobe |
| rd_grp_i | input | 3 | Group being read |
| stat_o | output | 2 | Bit 0 not ready, bit 1 completion flag |
| los_flag_o | output | NCH | Loss-of-signal flags |
| txf_flag_o | output | NCH | Transmitter fault flags |
| mod_flag_o | output | 4 | Module monitor flags |
| pwr_flag_o | output | 2*NCH | Lane power flags |
| int_n_o | output | 1 | Active-low interrupt, 1 means released |

## Verification
The hardest case to reach is a read that lands in the same cycle as a fresh or persisting condition. The clear and the set then act on one flag at one edge, and only the set must win. A vector table drives loss-of-signal, mask and read strobe together, cycle by cycle. Some rows read while the condition is held and some read after it has gone, so both outcomes of the clear are seen. The completion interrupt can only be reached through reset. The bench holds conditions active through the not-ready window, then counts edges to the exact cycle in which the not-ready bit drops.

// File: rtl/flagirq_pkg.sv
package flagirq_pkg;
    typedef enum logic [2:0] {
        GRP_LOS  = 3'd0,
        GRP_TXF  = 3'd1,
        GRP_STAT = 3'd2,
        GRP_MOD  = 3'd3,
        GRP_PWR  = 3'd4
    } grp_e;

    localparam int MOD_FLAGS = 4;
    localparam int STAT_W    = 2;

    // module monitor bit positions
    localparam int MB_TEMP_HI = 0;
    localparam int MB_TEMP_LO = 1;
    localparam int MB_VOLT_HI = 2;
    localparam int MB_VOLT_LO = 3;
endpackage

// File: rtl/fic_mon_cmp.sv
module fic_mon_cmp #(
    parameter int MW         = 16,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [MW-1:0] val_i,
    input  logic [MW-1:0] hi_lim_i,
    input  logic [MW-1:0] lo_lim_i,
    output logic          over_o,
    output logic          under_o
);
    generate
        if (SIGNED_CMP) begin : g_signed
            always_comb begin
                over_o  = $signed(val_i) > $signed(hi_lim_i);
                under_o = $signed(val_i) < $signed(lo_lim_i);
            end
        end else begin : g_unsigned
            always_comb begin
                over_o  = val_i > hi_lim_i;
                under_o = val_i < lo_lim_i;
            end
        end
    endgenerate
endmodule

// File: rtl/fic_flag_bank.sv
module fic_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // set wins over clear in the same cycle
        s_d.flag = (s_q.flag & ~{W{clr_i}}) | (set_i & {W{en_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;

    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    assert_set_survives_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (set_i != '0)) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    assert_no_latch_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ((flag_o & ~$past(flag_o)) == '0));
endmodule

// File: rtl/fic_init_seq.sv
module fic_init_seq #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic not_ready_o,
    output logic done_o
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (clr_i) begin
            s_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.busy <= 1'b1;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign not_ready_o = s_q.busy;
    assign done_o      = s_q.done;

    assert_done_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(not_ready_o) |-> done_o);

    assert_busy_never_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready_o |=> !not_ready_o);
endmodule

// File: rtl/flag_int_ctrl.sv
module flag_int_ctrl
    import flagirq_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int MW          = 16,
    parameter int INIT_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      los_i,
    input  logic [NCH-1:0]      txf_i,
    input  logic [MW-1:0]       temp_val_i,
    input  logic [MW-1:0]       temp_hi_lim_i,
    input  logic [MW-1:0]       temp_lo_lim_i,
    input  logic [MW-1:0]       volt_val_i,
    input  logic [MW-1:0]       volt_hi_lim_i,
    input  logic [MW-1:0]       volt_lo_lim_i,
    input  logic [NCH*MW-1:0]   pwr_val_i,
    input  logic [MW-1:0]       pwr_hi_lim_i,
    input  logic [MW-1:0]       pwr_lo_lim_i,
    input  logic [NCH-1:0]      los_mask_i,
    input  logic [NCH-1:0]      txf_mask_i,
    input  logic [3:0]          mod_mask_i,
    input  logic [2*NCH-1:0]    pwr_mask_i,
    input  logic                rd_stb_i,
    input  logic [2:0]          rd_grp_i,
    output logic [1:0]          stat_o,
    output logic [NCH-1:0]      los_flag_o,
    output logic [NCH-1:0]      txf_flag_o,
    output logic [3:0]          mod_flag_o,
    output logic [2*NCH-1:0]    pwr_flag_o,
    output logic                int_n_o
);
    localparam int PW = 2 * NCH;

    logic                 not_ready, done;
    logic                 latch_en;
    logic                 clr_los, clr_txf, clr_stat, clr_mod, clr_pwr;
    logic [MOD_FLAGS-1:0] mod_cond;
    logic [PW-1:0]        pwr_cond;
    grp_e                 grp;

    assign latch_en = !not_ready;
    assign grp      = grp_e'(rd_grp_i);

    always_comb begin
        clr_los  = 1'b0;
        clr_txf  = 1'b0;
        clr_stat = 1'b0;
        clr_mod  = 1'b0;
        clr_pwr  = 1'b0;
        if (rd_stb_i) begin
            case (grp)
                GRP_LOS:  clr_los  = 1'b1;
                GRP_TXF:  clr_txf  = 1'b1;
                GRP_STAT: clr_stat = 1'b1;
                GRP_MOD:  clr_mod  = 1'b1;
                GRP_PWR:  clr_pwr  = 1'b1;
                default:  ;
            endcase
        end
    end

    fic_mon_cmp #(.MW(MW), .SIGNED_CMP(1'b1)) u_temp_cmp (
        .val_i   (temp_val_i),
        .hi_lim_i(temp_hi_lim_i),
        .lo_lim_i(temp_lo_lim_i),
        .over_o  (mod_cond[MB_TEMP_HI]),
        .under_o (mod_cond[MB_TEMP_LO])
    );

    fic_mon_cmp #(.MW(MW), .SIGNED_CMP(1'b0)) u_volt_cmp (
        .val_i   (volt_val_i),
        .hi_lim_i(volt_hi_lim_i),
        .lo_lim_i(volt_lo_lim_i),
        .over_o  (mod_cond[MB_VOLT_HI]),
        .under_o (mod_cond[MB_VOLT_LO])
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_pwr
            fic_mon_cmp #(.MW(MW), .SIGNED_CMP(1'b0)) u_pwr_cmp (
                .val_i   (pwr_val_i[c*MW +: MW]),
                .hi_lim_i(pwr_hi_lim_i),
                .lo_lim_i(pwr_lo_lim_i),
                .over_o  (pwr_cond[2*c]),
                .under_o (pwr_cond[2*c+1])
            );
        end
    endgenerate

    fic_flag_bank #(.W(NCH)) u_los_bank (
        .clk(clk), .rst_n(rst_n), .en_i(latch_en),
        .set_i(los_i), .clr_i(clr_los), .flag_o(los_flag_o)
    );

    fic_flag_bank #(.W(NCH)) u_txf_bank (
        .clk(clk), .rst_n(rst_n), .en_i(latch_en),
        .set_i(txf_i), .clr_i(clr_txf), .flag_o(txf_flag_o)
    );

    fic_flag_bank #(.W(MOD_FLAGS)) u_mod_bank (
        .clk(clk), .rst_n(rst_n), .en_i(latch_en),
        .set_i(mod_cond), .clr_i(clr_mod), .flag_o(mod_flag_o)
    );

    fic_flag_bank #(.W(PW)) u_pwr_bank (
        .clk(clk), .rst_n(rst_n), .en_i(latch_en),
        .set_i(pwr_cond), .clr_i(clr_pwr), .flag_o(pwr_flag_o)
    );

    fic_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_stat),
        .not_ready_o(not_ready), .done_o(done)
    );

    assign stat_o = {done, not_ready};

    always_comb begin
        int_n_o = !( (|(los_flag_o & ~los_mask_i))
                   | (|(txf_flag_o & ~txf_mask_i))
                   | (|(mod_flag_o & ~mod_mask_i))
                   | (|(pwr_flag_o & ~pwr_mask_i))
                   | done );
    end

    assert_los_reaches_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[0] && (|(los_i & ~los_mask_i)))
        |=> (!int_n_o || (los_mask_i != $past(los_mask_i))));

    assert_txf_reaches_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[0] && (|(txf_i & ~txf_mask_i)))
        |=> (!int_n_o || (txf_mask_i != $past(txf_mask_i))));

    assert_ready_pulls_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[0]) |-> !int_n_o);
endmodule

// File: tb/flag_int_ctrl_tb.sv
`timescale 1ns/1ps
module flag_int_ctrl_tb;
    localparam int NCH  = 4;
    localparam int MW   = 16;
    localparam int INIT = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    los_i = '0, txf_i = '0;
    logic [MW-1:0]     temp_val = '0, temp_hi = 16'h7FFF, temp_lo = 16'h8000;
    logic [MW-1:0]     volt_val = 16'h4000, volt_hi = 16'hFFFF, volt_lo = '0;
    logic [NCH*MW-1:0] pwr_val = {NCH{16'h2000}};
    logic [MW-1:0]     pwr_hi = 16'hFFFF, pwr_lo = '0;
    logic [NCH-1:0]    los_mask = '0, txf_mask = '0;
    logic [3:0]        mod_mask = '0;
    logic [2*NCH-1:0]  pwr_mask = '0;
    logic              rd_stb = 1'b0;
    logic [2:0]        rd_grp = '0;
    logic [1:0]        stat;
    logic [NCH-1:0]    los_flag, txf_flag;
    logic [3:0]        mod_flag;
    logic [2*NCH-1:0]  pwr_flag;
    logic              int_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flag_int_ctrl #(.NCH(NCH), .MW(MW), .INIT_CYCLES(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .los_i(los_i), .txf_i(txf_i),
        .temp_val_i(temp_val), .temp_hi_lim_i(temp_hi), .temp_lo_lim_i(temp_lo),
        .volt_val_i(volt_val), .volt_hi_lim_i(volt_hi), .volt_lo_lim_i(volt_lo),
        .pwr_val_i(pwr_val), .pwr_hi_lim_i(pwr_hi), .pwr_lo_lim_i(pwr_lo),
        .los_mask_i(los_mask), .txf_mask_i(txf_mask), .mod_mask_i(mod_mask),
        .pwr_mask_i(pwr_mask), .rd_stb_i(rd_stb), .rd_grp_i(rd_grp),
        .stat_o(stat), .los_flag_o(los_flag), .txf_flag_o(txf_flag),
        .mod_flag_o(mod_flag), .pwr_flag_o(pwr_flag), .int_n_o(int_n)
    );

    // {los[3:0], mask[3:0], read, expected flags[3:0], expected int_n}
    localparam logic [13:0] VEC [11] = '{
        14'b0001_0000_0_0001_0,  // R1 latch
        14'b0000_0000_0_0001_0,  // R1 sticky
        14'b0000_0000_1_0000_1,  // R2 clear
        14'b0100_0000_1_0100_0,  // R3 set with read
        14'b0100_0000_1_0100_0,  // R3 persisting condition
        14'b0000_0100_0_0100_1,  // R4 masked
        14'b1000_0100_0_1100_0,  // R5 unmasked adds interrupt
        14'b0000_1100_0_1100_1,  // R4 all masked
        14'b0000_1100_1_0000_1,  // R2 clear masked
        14'b0010_1111_0_0010_1,  // R4 masked latch
        14'b0000_0000_1_0000_1   // R2 clear
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] g);
        rd_grp = g;
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        los_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset status", 32'(stat), 32'b01);
        chk("R9 reset int", 32'(int_n), 32'd1);
        chk("R9 reset flags", 32'(los_flag), 32'd0);
        repeat (INIT - 1) step();
        chk("R8 still not ready", 32'(stat), 32'b01);
        chk("R9 no latch while busy", 32'(los_flag), 32'd0);
        step();
        chk("R8 ready status", 32'(stat), 32'b10);
        chk("R8 completion interrupt", 32'(int_n), 32'd0);
        chk("R9 no latch at ready edge", 32'(los_flag), 32'd0);
        los_i = '0;
        rd(3'd2);
        chk("R8 status read clears", 32'(stat), 32'b00);
        chk("R8 int released", 32'(int_n), 32'd1);

        // table walk on the loss-of-signal group
        for (int i = 0; i < 11; i++) begin
            los_i    = VEC[i][13:10];
            los_mask = VEC[i][9:6];
            rd_stb   = VEC[i][5];
            rd_grp   = 3'd0;
            step();
            chk($sformatf("R1-R5 row %0d flags", i), 32'(los_flag), 32'(VEC[i][4:1]));
            chk($sformatf("R5 row %0d int", i), 32'(int_n), 32'(VEC[i][0]));
        end
        rd_stb   = 1'b0;
        los_mask = '0;

        // R7 signed temperature
        temp_hi = 16'd100; temp_lo = 16'hFFEC;   // -20
        temp_val = 16'hFFEB;                     // -21
        step();
        chk("R7 temp low", 32'(mod_flag), 32'b0010);
        chk("R5 temp int", 32'(int_n), 32'd0);
        temp_val = 16'd0;
        rd(3'd3);
        chk("R2 mod clear", 32'(mod_flag), 32'b0000);
        temp_val = 16'hFFEC;
        step();
        chk("R7 temp equal low", 32'(mod_flag), 32'b0000);
        temp_val = 16'd101;
        step();
        chk("R7 temp high", 32'(mod_flag), 32'b0001);
        temp_val = 16'd0;
        rd(3'd3);

        // R6 unsigned voltage
        volt_hi = 16'h8000; volt_lo = 16'h1000;
        volt_val = 16'hFFFF;
        step();
        chk("R6 volt high unsigned", 32'(mod_flag), 32'b0100);
        volt_val = 16'h8000;
        rd(3'd3);
        chk("R6 volt equal high", 32'(mod_flag), 32'b0000);
        volt_val = 16'h0FFF;
        step();
        chk("R6 volt low", 32'(mod_flag), 32'b1000);
        volt_val = 16'h2000;
        rd(3'd3);

        // R6 lane power, lane 2 high -> bit 4
        pwr_hi = 16'h8000; pwr_lo = 16'h1000;
        pwr_val[2*MW +: MW] = 16'h9000;
        step();
        chk("R6 lane2 power high", 32'(pwr_flag), 32'h10);
        pwr_val[2*MW +: MW] = 16'h2000;
        pwr_mask = 8'h10;
        step();
        chk("R4 masked power flag kept", 32'(pwr_flag), 32'h10);
        chk("R4 masked power int", 32'(int_n), 32'd1);
        pwr_mask = '0;
        rd(3'd4);
        chk("R2 power clear", 32'(pwr_flag), 32'h00);

        // R2 group independence
        txf_i = 4'b0010;
        step();
        txf_i = '0;
        los_i = 4'b0001;
        step();
        los_i = '0;
        rd(3'd0);
        chk("R2 los cleared", 32'(los_flag), 32'd0);
        chk("R2 txf untouched", 32'(txf_flag), 32'b0010);
        rd(3'd1);
        chk("R2 txf cleared", 32'(txf_flag), 32'd0);
        chk("R5 int released", 32'(int_n), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule